// File: doc/BRIEF.md
# UART Modem Control and Line Status

This block is the modem-control and line-status slice of a 16550-style UART that is reached through 32-bit registers. A control register holds a loopback enable and four modem output requests (data-terminal-ready, request-to-send and two general outputs). It drives the active-low modem pins from these requests. When loopback is on, it folds the serial transmit line and the modem outputs back onto the receive side inside the block, and the external inputs are ignored.

It also keeps a read-to-clear line status byte with three flags: transmit holding register empty, transmit shifter empty, and error-in-FIFO. The serial shifter, the baud generator and the FIFOs sit outside the block. They report through single-cycle strobes: a holding byte was loaded into the shifter, the shifter finished, and an errored character entered the receive FIFO. A small transmit occupancy state machine tracks whether the holding register and the shifter are full. It has three states. `TX_IDLE` means nothing is pending. `TX_BUSY` means the shifter is working and the holding register is empty. `TX_FULL` means the holding register contains a byte. The transitions are:

- `TX_IDLE`/`TX_BUSY` → `TX_FULL` on a transmit buffer write.
- `TX_FULL` → `TX_BUSY` on a load strobe without a write.
- `TX_BUSY` → `TX_IDLE` on a shift-done strobe.
- Any other combination stays in the current state.

Top module: `uart_mc_top`

## Requirements
- R1: After reset the control register is 0, all four active-low modem outputs are high, and the status register reads 0x60 (bits 6 and 5 set, bit 7 clear).
- R2: A write to offset 0x10 stores data bits 4:0 into the control register: bit 4 loopback, bit 3 general output 2, bit 2 general output 1, bit 1 request-to-send, bit 0 terminal-ready. A read of offset 0x10 returns those five bits, and bits 31:5 read 0.
- R3: `dtr_n` is low exactly when control bit 0 is 1, and `rts_n` is low exactly when control bit 1 is 1.
- R4: `out1_n` is low only when loopback and control bit 2 are both 1, and `out2_n` is low only when loopback and control bit 3 are both 1. Otherwise both stay high.
- R5: With loopback on, `txd_pin` is 1 and `rx_core` follows `tx_ser`. With loopback off, `txd_pin` follows `tx_ser` and `rx_core` follows `rxd_pin`.
- R6: With loopback on, `dsr` follows control bit 0, `cts` follows bit 1, `ri` follows bit 2 and `dcd` follows bit 3, and the four modem input pins have no effect. With loopback off, each of these outputs is the inverse of its active-low pin.
- R7: The status register is at offset 0x1C and bits 31:8 read 0. Bit 7 becomes 1 on the cycle after an `rx_err_stb` pulse.
- R8: A write to the transmit buffer at offset 0x00 clears status bits 6 and 5 on the following cycle.
- R9: A status read returns the flags as they were before the read. On the next cycle all three flags are 0, unless a set event arrived in the cycle of the read; a set takes priority over the clear.
- R10: A `tx_load_stb` while the holding register is full sets status bit 5. A `tx_load_stb` while the holding register is empty has no effect.
- R11: A `tx_done_stb` while the shifter is busy and the holding register is empty sets status bit 6. A `tx_done_stb` while the holding register is full has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid while reg_rd is high |
| tx_ser | input | 1 | Serial output of the external shifter |
| tx_load_stb | input | 1 | Shifter took the holding byte |
| tx_done_stb | input | 1 | Shifter finished its character |
| rx_err_stb | input | 1 | Errored character entered the receive FIFO |
| rxd_pin | input | 1 | External serial receive pin |
| txd_pin | output | 1 | External serial transmit pin |
| rx_core | output | 1 | Serial line to the receiver |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| cts_n | input | 1 | Clear-to-send pin, active low |
| ri_n | input | 1 | Ring-indicator pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| dsr | output | 1 | Effective data-set-ready, active high |
| cts | output | 1 | Effective clear-to-send, active high |
| ri | output | 1 | Effective ring indicator, active high |
| dcd | output | 1 | Effective carrier detect, active high |

## Verification
The bench builds the block with its default parameters: an 8-bit byte offset, 32-bit data, and the buffer, control and status registers at 0x00, 0x10 and 0x1C. With these values it can write all ones to the control register and show that the reserved bits stay clear. It also compares the status byte directly with constants such as 0x60, 0x20 and 0x40. The 32-bit width makes it possible to check that the upper 24 bits of the status register read zero. The default offsets let it drive a transmit buffer write, a load strobe and a done strobe in sequence through all three occupancy states. This reaches the ignored-strobe cases in `TX_IDLE` and `TX_FULL`, and a status read that coincides with an error strobe.

// File: rtl/uart_mc_pkg.sv
package uart_mc_pkg;

    localparam int MCR_W    = 5;
    localparam int LSR_W    = 8;
    localparam int ERR_BIT  = 7;
    localparam int TEMT_BIT = 6;
    localparam int THRE_BIT = 5;
    localparam int N_MODEM  = 4;

    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } mcr_t;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_BUSY = 2'd1,
        TX_FULL = 2'd2
    } tx_state_e;

endpackage

// File: rtl/uart_mc_modem.sv
module uart_mc_modem
    import uart_mc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mcr_wr,
    input  logic [MCR_W-1:0]   mcr_wdata,
    input  logic               tx_ser,
    input  logic               rxd_pin,
    input  logic [N_MODEM-1:0] mdm_in_n,
    output mcr_t               mcr_q,
    output logic               txd_pin,
    output logic               rx_core,
    output logic               dtr_n,
    output logic               rts_n,
    output logic               out1_n,
    output logic               out2_n,
    output logic [N_MODEM-1:0] mdm_stat
);

    logic [N_MODEM-1:0] loop_src;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcr_q <= '0;
        end else if (mcr_wr) begin
            mcr_q <= mcr_t'(mcr_wdata);
        end
    end

    always_comb begin
        dtr_n   = !mcr_q.dtr;
        rts_n   = !mcr_q.rts;
        out1_n  = !(mcr_q.loop && mcr_q.out1);
        out2_n  = !(mcr_q.loop && mcr_q.out2);
        txd_pin = mcr_q.loop ? 1'b1   : tx_ser;
        rx_core = mcr_q.loop ? tx_ser : rxd_pin;
    end

    // index 0 dsr, 1 cts, 2 ri, 3 dcd
    assign loop_src = {mcr_q.out2, mcr_q.out1, mcr_q.rts, mcr_q.dtr};

    genvar gi;
    generate
        for (gi = 0; gi < N_MODEM; gi++) begin : g_cross
            assign mdm_stat[gi] = mcr_q.loop ? loop_src[gi] : !mdm_in_n[gi];
        end
    endgenerate

    // R5
    txd_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_q.loop |-> (txd_pin && (rx_core == tx_ser)));

    // R4
    out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mcr_q.loop |-> (out1_n && out2_n));

    // R6
    loop_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_q.loop |-> ((mdm_stat[0] == !dtr_n) && (mdm_stat[1] == !rts_n)
                        && (mdm_stat[2] == !out1_n) && (mdm_stat[3] == !out2_n)));

endmodule

// File: rtl/uart_mc_txtrack.sv
module uart_mc_txtrack
    import uart_mc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic thr_wr,
    input  logic load_stb,
    input  logic done_stb,
    output logic load_ok,
    output logic done_ok
);

    tx_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        load_ok = 1'b0;
        done_ok = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (thr_wr) state_d = TX_FULL;
            end
            TX_BUSY: begin
                if (thr_wr) begin
                    state_d = TX_FULL;
                end else if (done_stb) begin
                    state_d = TX_IDLE;
                    done_ok = 1'b1;
                end
            end
            TX_FULL: begin
                if (!thr_wr && load_stb) begin
                    state_d = TX_BUSY;
                    load_ok = 1'b1;
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // R10
    load_from_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_FULL && load_stb && !thr_wr) |=> (state_q == TX_BUSY));

    // R11
    done_in_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_FULL && done_stb) |=> (state_q != TX_IDLE));

endmodule

// File: rtl/uart_mc_status.sv
module uart_mc_status
    import uart_mc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_wr,
    input  logic             load_ok,
    input  logic             done_ok,
    input  logic             rx_err,
    input  logic             rd_clr,
    output logic [LSR_W-1:0] lsr
);

    logic err_q, temt_q, thre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            temt_q <= 1'b1;
            thre_q <= 1'b1;
        end else begin
            if (rx_err)       err_q <= 1'b1;
            else if (rd_clr)  err_q <= 1'b0;

            if (thr_wr)       thre_q <= 1'b0;
            else if (load_ok) thre_q <= 1'b1;
            else if (rd_clr)  thre_q <= 1'b0;

            if (thr_wr)       temt_q <= 1'b0;
            else if (done_ok) temt_q <= 1'b1;
            else if (rd_clr)  temt_q <= 1'b0;
        end
    end

    always_comb begin
        lsr           = '0;
        lsr[ERR_BIT]  = err_q;
        lsr[TEMT_BIT] = temt_q;
        lsr[THRE_BIT] = thre_q;
    end

    // R8
    thr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> (!lsr[TEMT_BIT] && !lsr[THRE_BIT]));

    // R7
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |=> lsr[ERR_BIT]);

    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !rx_err && !thr_wr && !load_ok && !done_ok) |=> (lsr == '0));

endmodule

// File: rtl/uart_mc_top.sv
module uart_mc_top
    import uart_mc_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int THR_OFS = 'h00,
    parameter int MCR_OFS = 'h10,
    parameter int LSR_OFS = 'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tx_ser,
    input  logic              tx_load_stb,
    input  logic              tx_done_stb,
    input  logic              rx_err_stb,
    input  logic              rxd_pin,
    output logic              txd_pin,
    output logic              rx_core,
    input  logic              dsr_n,
    input  logic              cts_n,
    input  logic              ri_n,
    input  logic              dcd_n,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              out1_n,
    output logic              out2_n,
    output logic              dsr,
    output logic              cts,
    output logic              ri,
    output logic              dcd
);

    localparam logic [ADDR_W-1:0] A_THR = ADDR_W'(THR_OFS);
    localparam logic [ADDR_W-1:0] A_MCR = ADDR_W'(MCR_OFS);
    localparam logic [ADDR_W-1:0] A_LSR = ADDR_W'(LSR_OFS);
    localparam int MCR_PAD = DATA_W - MCR_W;
    localparam int LSR_PAD = DATA_W - LSR_W;

    logic               sel_thr, sel_mcr, sel_lsr;
    logic               thr_wr, mcr_wr, lsr_rd;
    logic               load_ok, done_ok;
    logic [LSR_W-1:0]   lsr;
    logic [N_MODEM-1:0] mdm_stat;
    mcr_t               mcr_q;
    logic               unused_wbits;

    assign sel_thr = (reg_addr == A_THR);
    assign sel_mcr = (reg_addr == A_MCR);
    assign sel_lsr = (reg_addr == A_LSR);
    assign thr_wr  = reg_wr && sel_thr;
    assign mcr_wr  = reg_wr && sel_mcr;
    assign lsr_rd  = reg_rd && sel_lsr;
    assign unused_wbits = ^reg_wdata[DATA_W-1:MCR_W];

    uart_mc_modem u_modem (
        .clk       (clk),
        .rst_n     (rst_n),
        .mcr_wr    (mcr_wr),
        .mcr_wdata (reg_wdata[MCR_W-1:0]),
        .tx_ser    (tx_ser),
        .rxd_pin   (rxd_pin),
        .mdm_in_n  ({dcd_n, ri_n, cts_n, dsr_n}),
        .mcr_q     (mcr_q),
        .txd_pin   (txd_pin),
        .rx_core   (rx_core),
        .dtr_n     (dtr_n),
        .rts_n     (rts_n),
        .out1_n    (out1_n),
        .out2_n    (out2_n),
        .mdm_stat  (mdm_stat)
    );

    uart_mc_txtrack u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr_wr   (thr_wr),
        .load_stb (tx_load_stb),
        .done_stb (tx_done_stb),
        .load_ok  (load_ok),
        .done_ok  (done_ok)
    );

    uart_mc_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .thr_wr  (thr_wr),
        .load_ok (load_ok),
        .done_ok (done_ok),
        .rx_err  (rx_err_stb),
        .rd_clr  (lsr_rd),
        .lsr     (lsr)
    );

    assign {dcd, ri, cts, dsr} = mdm_stat;

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (sel_mcr)      reg_rdata = {{MCR_PAD{1'b0}}, mcr_q};
            else if (sel_lsr) reg_rdata = {{LSR_PAD{1'b0}}, lsr};
        end
    end

    // R3
    pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_wr |=> ((dtr_n == !$past(reg_wdata[0])) && (rts_n == !$past(reg_wdata[1]))));

    // R2
    mcr_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && sel_mcr) |-> (reg_rdata[DATA_W-1:MCR_W] == '0));

endmodule

// File: tb/tb_uart_mc_top.sv
module tb_uart_mc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_ser = 1'b1, tx_load_stb = 1'b0, tx_done_stb = 1'b0, rx_err_stb = 1'b0;
    logic        rxd_pin = 1'b1;
    logic        txd_pin, rx_core;
    logic        dsr_n = 1'b1, cts_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic        dtr_n, rts_n, out1_n, out2_n, dsr, cts, ri, dcd;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    uart_mc_top dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_ser(tx_ser),
        .tx_load_stb(tx_load_stb), .tx_done_stb(tx_done_stb), .rx_err_stb(rx_err_stb),
        .rxd_pin(rxd_pin), .txd_pin(txd_pin), .rx_core(rx_core),
        .dsr_n(dsr_n), .cts_n(cts_n), .ri_n(ri_n), .dcd_n(dcd_n),
        .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
        .dsr(dsr), .cts(cts), .ri(ri), .dcd(dcd)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse_load();
        @(negedge clk); tx_load_stb = 1'b1;
        @(negedge clk); tx_load_stb = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); tx_done_stb = 1'b1;
        @(negedge clk); tx_done_stb = 1'b0;
    endtask

    task automatic pins_now(output logic [3:0] p);
        #1 p = {out2_n, out1_n, rts_n, dtr_n};
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic [3:0]  p;
        pins_now(p);
        chk({28'd0, p}, 32'hF, "R1 pins");
        rd(8'h10, d);
        chk(d, 32'h0, "R1 mcr");
        rd(8'h1C, d);
        chk(d, 32'h60, "R1 lsr");
        rd(8'h1C, d);
        chk(d, 32'h0, "R9 cleared after read");
    endtask

    task automatic t_mcr();
        logic [31:0] d;
        logic [3:0]  p;
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, d);
        chk(d, 32'h1F, "R2 readback");
        pins_now(p);
        chk({28'd0, p}, 32'h0, "R4 loop pins low");
        wr(8'h10, 32'h0000_000F);
        pins_now(p);
        chk({28'd0, p}, 32'hC, "R4 out pins high without loop");
        wr(8'h10, 32'h0000_0001);
        pins_now(p);
        chk({28'd0, p}, 32'hE, "R3 dtr only");
        wr(8'h10, 32'h0000_0002);
        pins_now(p);
        chk({28'd0, p}, 32'hD, "R3 rts only");
    endtask

    task automatic t_serial();
        wr(8'h10, 32'h10);
        @(negedge clk); tx_ser = 1'b0; rxd_pin = 1'b1;
        #1 chk({30'd0, txd_pin, rx_core}, 32'h2, "R5 loop tx low");
        @(negedge clk); tx_ser = 1'b1; rxd_pin = 1'b0;
        #1 chk({30'd0, txd_pin, rx_core}, 32'h3, "R5 loop tx high");
        wr(8'h10, 32'h0);
        @(negedge clk); tx_ser = 1'b0; rxd_pin = 1'b1;
        #1 chk({30'd0, txd_pin, rx_core}, 32'h1, "R5 normal a");
        @(negedge clk); tx_ser = 1'b1; rxd_pin = 1'b0;
        #1 chk({30'd0, txd_pin, rx_core}, 32'h2, "R5 normal b");
    endtask

    task automatic t_modem();
        wr(8'h10, 32'h15);
        @(negedge clk); dsr_n = 1'b1; cts_n = 1'b0; ri_n = 1'b1; dcd_n = 1'b0;
        #1 chk({28'd0, dcd, ri, cts, dsr}, 32'h5, "R6 loop cross, pins ignored");
        wr(8'h10, 32'h1A);
        #1 chk({28'd0, dcd, ri, cts, dsr}, 32'hA, "R6 loop cross b");
        wr(8'h10, 32'h0);
        @(negedge clk); dsr_n = 1'b0; cts_n = 1'b1; ri_n = 1'b1; dcd_n = 1'b0;
        #1 chk({28'd0, dcd, ri, cts, dsr}, 32'h9, "R6 normal inputs");
        @(negedge clk); dsr_n = 1'b1; dcd_n = 1'b1;
    endtask

    task automatic t_err();
        logic [31:0] d;
        @(negedge clk); rx_err_stb = 1'b1;
        @(negedge clk); rx_err_stb = 1'b0;
        rd(8'h1C, d);
        chk(d, 32'h80, "R7 error flag, upper zero");
        rd(8'h1C, d);
        chk(d, 32'h0, "R9 error cleared");
        @(negedge clk); reg_addr = 8'h1C; reg_rd = 1'b1; rx_err_stb = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0; rx_err_stb = 1'b0;
        chk(d, 32'h0, "R9 pre-clear value");
        rd(8'h1C, d);
        chk(d, 32'h80, "R9 set beats clear");
    endtask

    task automatic t_tx();
        logic [31:0] d;
        pulse_load();
        rd(8'h1C, d);
        chk(d, 32'h0, "R10 load ignored when empty");
        wr(8'h1C, 32'h0);
        wr(8'h00, 32'h41);
        rd(8'h1C, d);
        chk(d, 32'h0, "R8 write clears");
        pulse_done();
        rd(8'h1C, d);
        chk(d, 32'h0, "R11 done ignored while full");
        pulse_load();
        rd(8'h1C, d);
        chk(d, 32'h20, "R10 load sets holding empty");
        pulse_done();
        rd(8'h1C, d);
        chk(d, 32'h40, "R11 done sets shifter empty");
        pulse_done();
        rd(8'h1C, d);
        chk(d, 32'h0, "R11 done ignored when idle");
    endtask

    task automatic t_r8_flags();
        logic [31:0] d;
        wr(8'h00, 32'h42);
        pulse_load();
        pulse_done();
        wr(8'h00, 32'h43);
        rd(8'h1C, d);
        chk(d, 32'h0, "R8 both flags cleared by write");
        pulse_load();
        pulse_done();
        rd(8'h1C, d);
        chk(d, 32'h60, "R10 R11 both flags set");
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mcr();
        t_serial();
        t_modem();
        t_err();
        t_tx();
        t_r8_flags();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule